// File: doc/BRIEF.md
# Predictive Synchronous Rectifier Gate Timer

This block produces the two gate enables for the secondary rectifiers of a forward converter. A synchronising square wave from the primary side sets the timing. The block runs on a fast tick clock and counts how many ticks each high phase and each low phase of that wave lasts. It assumes the next period will repeat the last one. From that assumption it ends each gate pulse a chosen number of ticks before the edge that is expected to close the phase. The resulting gap is the dead time between the rectifier device and the freewheeling device.

The rectifier gate follows the high phase and always has a fixed lead of `ANT1` ticks. The freewheeling gate follows the low phase, and a two-bit select chooses its lead. The inhibit input shortens the freewheeling pulse to a short minimum conduction time, which allows discontinuous conduction. An optional guard turns both gates off when the measured duty cycle is too small. A status output shows when the gates are allowed to run.

Top module: `sr_gate_timer`

## Requirements
- R1: After reset, `gate_rect`, `gate_free` and `status` are 0. They stay 0 until two complete synchronising periods have been measured. `status` first goes to 1 on the second tick of the third high phase after reset, when the input starts low.
- R2: The tick on which `sync_in` becomes 1 is tick 1 of a high phase. `gate_rect` is 1 on ticks 2 through P−4 of that phase, where P is the length of the previous high phase. On all other ticks it is 0.
- R3: The tick on which `sync_in` becomes 0 is tick 1 of a low phase. `gate_free` is 1 on ticks 2 through P−A of that phase, where P is the length of the previous low phase and A is the selected lead. The phase counter saturates instead of wrapping.
- R4: The freewheeling lead A is set by `ant_sel`. Codes 0 and 1 give 4 ticks, code 2 gives 8 ticks, and code 3 gives 12 ticks.
- R5: While `inhibit` is 1, `gate_free` is also 0 after tick 9 of the low phase. This gives at most 8 ticks of conduction.
- R6: An actual edge on `sync_in` turns off the gate of the phase that is ending, on the same tick. This holds even when the prediction from the previous period called for a longer pulse.
- R7: If the previous phase was too short for its lead (P−lead < 2), the gate gets no pulse in that phase.
- R8: While `lowduty_en` is 1 and H·100 < (H+L)·13, both gates and `status` are 0. H and L are the latest measured high and low lengths. While `lowduty_en` is 0, this test has no effect.
- R9: `gate_rect` and `gate_free` are never 1 on the same tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast tick clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_in | input | 1 | Synchronising converter clock, already sampled into the tick domain |
| ant_sel | input | 2 | Lead select for the freewheeling gate |
| inhibit | input | 1 | Limits the freewheeling gate to its minimum conduction time |
| lowduty_en | input | 1 | Enables the low-duty-cycle shutdown |
| gate_rect | output | 1 | Rectifier gate enable (high phase) |
| gate_free | output | 1 | Freewheeling gate enable (low phase) |
| status | output | 1 | Gates allowed to run (measured and not shut down) |

## Verification
The gates and `status` are combinational functions of the present `sync_in`, `inhibit`, `lowduty_en` and `ant_sel`, together with state registered up to the previous tick. The response to a tick's inputs is therefore due within that same tick. A length measured at an edge first takes effect one tick after that edge. The bench drives every input on the falling clock edge and records the expected outputs for that tick in a queue. A monitor reads the outputs 2 ns later, which is still within the same tick. The reference model in the bench updates its copy of the measured lengths only after it has produced the expectation for the edge tick, so each check sees the same one-tick lag as the design.

// File: rtl/sr_timer_pkg.sv
package sr_timer_pkg;

   // Encoding of the freewheeling lead select
   typedef enum logic [1:0] {
      LEAD_SHORT_ALT = 2'd0,
      LEAD_SHORT     = 2'd1,
      LEAD_MID       = 2'd2,
      LEAD_LONG      = 2'd3
   } lead_sel_e;

   // Number of edges needed before two whole periods are known:
   // the first edge only closes a partial phase after reset
   function automatic int lock_edges(input int periods);
      return 2 * periods + 1;
   endfunction

endpackage

// File: rtl/sr_phase_meter.sv
module sr_phase_meter #(
   parameter int CNT_W        = 12,
   parameter int LOCK_PERIODS = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sync_in,
   output logic             sync_q,
   output logic [CNT_W-1:0] ph_cnt,
   output logic [CNT_W-1:0] hi_len,
   output logic [CNT_W-1:0] lo_len,
   output logic             locked
);
   localparam int               LOCK_N = sr_timer_pkg::lock_edges(LOCK_PERIODS);
   localparam int               EW     = $clog2(LOCK_N + 1);
   localparam logic [CNT_W-1:0] CMAX   = {CNT_W{1'b1}};

   if (LOCK_PERIODS < 1) begin : g_bad_lock
      $error("sr_phase_meter: LOCK_PERIODS must be at least 1");
   end

   logic          edge_now;
   logic [EW-1:0] edge_cnt;

   assign edge_now = sync_in ^ sync_q;
   assign locked   = (edge_cnt == EW'(LOCK_N));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sync_q   <= 1'b0;
         ph_cnt   <= '0;
         hi_len   <= '0;
         lo_len   <= '0;
         edge_cnt <= '0;
      end else begin
         sync_q <= sync_in;
         if (edge_now) begin
            ph_cnt <= CNT_W'(1);
            if (sync_in) lo_len <= ph_cnt;
            else         hi_len <= ph_cnt;
            if (edge_cnt != EW'(LOCK_N)) edge_cnt <= edge_cnt + EW'(1);
         end else if (ph_cnt != CMAX) begin
            ph_cnt <= ph_cnt + CNT_W'(1);
         end
      end
   end

   // R3
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_cnt == CMAX && !edge_now) |=> (ph_cnt == CMAX));

endmodule

// File: rtl/sr_duty_guard.sv
module sr_duty_guard #(
   parameter int CNT_W    = 12,
   parameter int DUTY_PCT = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] hi_len,
   input  logic [CNT_W-1:0] lo_len,
   input  logic             locked,
   input  logic             lowduty_en,
   output logic             run
);
   localparam int PW = CNT_W + 8;

   if (DUTY_PCT < 1 || DUTY_PCT > 99) begin : g_bad_pct
      $error("sr_duty_guard: DUTY_PCT must lie in 1..99");
   end

   logic [PW-1:0] hi_scaled;
   logic [PW-1:0] per_scaled;
   logic          too_short;

   assign hi_scaled  = PW'(hi_len) * PW'(100);
   assign per_scaled = (PW'(hi_len) + PW'(lo_len)) * PW'(DUTY_PCT);
   assign too_short  = hi_scaled < per_scaled;
   assign run        = locked && !(lowduty_en && too_short);

   // R8
   guard_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && !lowduty_en) |-> run);

endmodule

// File: rtl/sr_gate_window.sv
module sr_gate_window #(
   parameter int CNT_W     = 12,
   parameter bit LEVEL     = 1'b1,
   parameter bit HAS_CAP   = 1'b0,
   parameter int CAP_TICKS = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sync_in,
   input  logic             sync_q,
   input  logic             run,
   input  logic [CNT_W-1:0] ph_cnt,
   input  logic [CNT_W-1:0] pred_len,
   input  logic [CNT_W-1:0] lead,
   input  logic             cap_en,
   output logic             gate
);
   localparam int AW = CNT_W + 2;

   if (CAP_TICKS < 1 || CAP_TICKS >= (1 << CNT_W)) begin : g_bad_cap
      $error("sr_gate_window: CAP_TICKS out of range");
   end

   logic          in_phase;
   logic          before_end;
   logic          capped;
   logic [AW-1:0] end_pos;

   // ph_cnt holds (tick index - 1) once the phase is past its first tick
   assign in_phase   = (sync_in == LEVEL) && (sync_q == LEVEL) && (ph_cnt != '0);
   assign end_pos    = AW'(ph_cnt) + AW'(lead) + AW'(1);
   assign before_end = end_pos <= AW'(pred_len);
   assign capped     = HAS_CAP && cap_en && (ph_cnt > CNT_W'(CAP_TICKS));
   assign gate       = run && in_phase && before_end && !capped;

   if (HAS_CAP) begin : g_cap_chk
      // R5
      min_on_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (cap_en && ph_cnt > CNT_W'(CAP_TICKS)) |-> !gate);
   end

endmodule

// File: rtl/sr_gate_timer.sv
module sr_gate_timer #(
   parameter int CNT_W        = 12,
   parameter int ANT1         = 4,
   parameter int ANT2_SHORT   = 4,
   parameter int ANT2_MID     = 8,
   parameter int ANT2_LONG    = 12,
   parameter int MIN_ON       = 8,
   parameter int DUTY_PCT     = 13,
   parameter int LOCK_PERIODS = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sync_in,
   input  logic [1:0] ant_sel,
   input  logic       inhibit,
   input  logic       lowduty_en,
   output logic       gate_rect,
   output logic       gate_free,
   output logic       status
);
   import sr_timer_pkg::*;

   localparam int NGATE = 2;

   if (CNT_W < 10) begin : g_bad_width
      $error("sr_gate_timer: CNT_W too small for the slowest period");
   end
   if (ANT1 >= (1 << CNT_W) || ANT2_LONG >= (1 << CNT_W)) begin : g_bad_lead
      $error("sr_gate_timer: lead value does not fit CNT_W");
   end

   logic             sync_q;
   logic             locked;
   logic             run;
   logic [CNT_W-1:0] ph_cnt;
   logic [CNT_W-1:0] hi_len;
   logic [CNT_W-1:0] lo_len;
   logic [CNT_W-1:0] lead2;

   always_comb begin
      case (lead_sel_e'(ant_sel))
         LEAD_MID:  lead2 = CNT_W'(ANT2_MID);
         LEAD_LONG: lead2 = CNT_W'(ANT2_LONG);
         default:   lead2 = CNT_W'(ANT2_SHORT);
      endcase
   end

   sr_phase_meter #(.CNT_W(CNT_W), .LOCK_PERIODS(LOCK_PERIODS)) i_meter (
      .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .sync_q(sync_q),
      .ph_cnt(ph_cnt), .hi_len(hi_len), .lo_len(lo_len), .locked(locked)
   );

   sr_duty_guard #(.CNT_W(CNT_W), .DUTY_PCT(DUTY_PCT)) i_guard (
      .clk(clk), .rst_n(rst_n), .hi_len(hi_len), .lo_len(lo_len),
      .locked(locked), .lowduty_en(lowduty_en), .run(run)
   );

   // index 0: rectifier gate (high phase), index 1: freewheeling gate (low phase)
   logic [CNT_W-1:0] pred_a [NGATE];
   logic [CNT_W-1:0] lead_a [NGATE];
   logic             cap_a  [NGATE];
   logic             gate_a [NGATE];

   assign pred_a[0] = hi_len;
   assign pred_a[1] = lo_len;
   assign lead_a[0] = CNT_W'(ANT1);
   assign lead_a[1] = lead2;
   assign cap_a[0]  = 1'b0;
   assign cap_a[1]  = inhibit;

   for (genvar g = 0; g < NGATE; g++) begin : g_win
      sr_gate_window #(
         .CNT_W(CNT_W), .LEVEL(g == 0), .HAS_CAP(g == 1), .CAP_TICKS(MIN_ON)
      ) i_win (
         .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .sync_q(sync_q),
         .run(run), .ph_cnt(ph_cnt), .pred_len(pred_a[g]), .lead(lead_a[g]),
         .cap_en(cap_a[g]), .gate(gate_a[g])
      );
   end

   assign gate_rect = gate_a[0];
   assign gate_free = gate_a[1];
   assign status    = run;

   // R9
   no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate_rect && gate_free));

   // R6
   edge_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_in != sync_q) |-> (!gate_rect && !gate_free));

   // R1
   idle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !status |-> (!gate_rect && !gate_free));

   // R2
   rect_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gate_rect |-> (sync_in && sync_q));

endmodule

// File: tb/test_sr_gate_timer.sv
module test_sr_gate_timer;

   typedef struct {
      logic  r;
      logic  f;
      logic  s;
      string tag;
      int    tick;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sync_in = 1'b0;
   logic [1:0] ant_sel = 2'd1;
   logic       inhibit = 1'b0;
   logic       lowduty_en = 1'b0;
   logic       gate_rect, gate_free, status;

   int   checks = 0;
   int   errors = 0;
   exp_t q[$];

   // reference model state
   bit m_prev = 1'b0;
   int m_hi = 0, m_lo = 0, m_last = 0, m_edges = 0;

   always #5 clk = ~clk;

   sr_gate_timer i_sr_gate_timer (
      .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .ant_sel(ant_sel),
      .inhibit(inhibit), .lowduty_en(lowduty_en),
      .gate_rect(gate_rect), .gate_free(gate_free), .status(status)
   );

   function automatic int lead_of(input logic [1:0] sel);
      // R4: codes 0,1 -> 4, 2 -> 8, 3 -> 12
      case (sel)
         2'd2:    return 8;
         2'd3:    return 12;
         default: return 4;
      endcase
   endfunction

   task automatic run_phase(input bit level, input int len, input logic [1:0] sel,
                            input bit inh, input bit ld, input string tag);
      for (int k = 1; k <= len; k++) begin
         exp_t e;
         bit   st;
         @(negedge clk);
         sync_in    = level;
         ant_sel    = sel;
         inhibit    = inh;
         lowduty_en = ld;
         // R8 shutdown test, R1 lock after five edges
         st = (m_edges >= 5) && !(ld && (m_hi * 100 < (m_hi + m_lo) * 13));
         e.s    = st;
         e.r    = st && level && (k >= 2) && (k + 4 <= m_hi);
         e.f    = st && !level && (k >= 2) && (k + lead_of(sel) <= m_lo) &&
                  (!inh || k <= 9);
         e.tag  = tag;
         e.tick = k;
         q.push_back(e);
         if (k == 1 && level != m_prev) begin
            if (level) m_lo = m_last;
            else       m_hi = m_last;
            if (m_edges < 5) m_edges++;
            m_prev = level;
         end
      end
      m_last = len;
   endtask

   task automatic period(input int h, input int l, input logic [1:0] sel,
                         input bit inh, input bit ld, input string tag);
      run_phase(1'b1, h, sel, inh, ld, tag);
      run_phase(1'b0, l, sel, inh, ld, tag);
   endtask

   // monitor / scoreboard
   initial begin
      forever begin
         @(negedge clk);
         #2;
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (gate_rect !== e.r || gate_free !== e.f || status !== e.s) begin
               errors++;
               $display("FAIL %s tick %0d: got rect=%b free=%b status=%b exp rect=%b free=%b status=%b",
                        e.tag, e.tick, gate_rect, gate_free, status, e.r, e.f, e.s);
            end
            checks++;
            if (gate_rect && gate_free) begin
               errors++;
               $display("FAIL R9 tick %0d: got rect=1 free=1 exp not both", e.tick);
            end
         end
      end
   end

   // watchdog
   initial begin
      #1500000;
      errors++;
      $display("FAIL watchdog: got run still active exp finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      #2;
      checks++;  // R1 reset state
      if (gate_rect !== 1'b0 || gate_free !== 1'b0 || status !== 1'b0) begin
         errors++;
         $display("FAIL R1 reset: got rect=%b free=%b status=%b exp 0 0 0",
                  gate_rect, gate_free, status);
      end
      @(negedge clk);
      rst_n = 1'b1;

      run_phase(1'b0, 5, 2'd1, 1'b0, 1'b0, "R1");
      repeat (2) period(30, 40, 2'd1, 1'b0, 1'b0, "R1");
      repeat (2) period(30, 40, 2'd1, 1'b0, 1'b0, "R2 R3");
      // R4 lead codes
      period(30, 40, 2'd2, 1'b0, 1'b0, "R4");
      period(30, 40, 2'd3, 1'b0, 1'b0, "R4");
      period(30, 40, 2'd0, 1'b0, 1'b0, "R4");
      // R5 inhibit cap
      period(30, 40, 2'd1, 1'b1, 1'b0, "R5");
      period(30, 40, 2'd3, 1'b1, 1'b0, "R5");
      // R6 phases shorter than predicted
      period(20, 25, 2'd1, 1'b0, 1'b0, "R6");
      period(30, 40, 2'd1, 1'b0, 1'b0, "R6");
      // R7 phases shorter than the lead
      period(4, 40, 2'd1, 1'b0, 1'b0, "R7");
      period(4, 3, 2'd1, 1'b0, 1'b0, "R7");
      period(30, 40, 2'd1, 1'b0, 1'b0, "R7");
      // R8 low-duty shutdown and its boundary
      period(30, 40, 2'd1, 1'b0, 1'b1, "R8");
      repeat (2) period(4, 40, 2'd1, 1'b0, 1'b1, "R8");
      repeat (2) period(13, 87, 2'd1, 1'b0, 1'b1, "R8");
      repeat (2) period(12, 88, 2'd1, 1'b0, 1'b1, "R8");
      repeat (2) period(12, 88, 2'd1, 1'b0, 1'b0, "R8");

      repeat (4) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule